// File: doc/BRIEF.md
# Iterative Integer Divide Unit

This block is a sequential integer divider for a processor's execute stage. It serves four operations: the signed quotient, the unsigned quotient, the signed remainder and the unsigned remainder of two `DATA_W`-bit operands. A request is taken on a single `start_i` pulse while the unit is idle. The unit then runs one shift-subtract step per clock on the operand magnitudes, fixes the signs, and presents one result word with `done_o` set. That result stays in place until the consumer pulses `ack_i`.

The quotient rounds toward zero. A signed remainder carries the sign of the dividend. The block never raises an exception. A zero divisor and the one signed overflow case (most negative value divided by minus one) each produce a fixed, defined result.

Top module: `int_div_unit`

## Requirements
- R1: With `op_i` = 2'b01 the result is the unsigned quotient of `dividend_i` by `divisor_i`, rounded down.
- R2: With `op_i` = 2'b00 the operands are two's complement, and the result is the quotient truncated toward zero.
- R3: With `op_i` = 2'b10 the result is the signed remainder. It is zero or has the dividend's sign, and it satisfies dividend = quotient * divisor + remainder.
- R4: With `op_i` = 2'b11 the result is the remainder of the unsigned division.
- R5: When the divisor is zero, both quotient operations return all ones and both remainder operations return the dividend unchanged.
- R6: In signed mode, the most negative value divided by all ones (-1) gives the most negative value as the quotient (op 00) and zero as the remainder (op 10).
- R7: `start_i` is accepted only while `busy_o` is low. A start pulse seen while busy, whether computing or holding a result, changes neither the result nor the state.
- R8: `done_o` rises on the `DATA_W`-th rising clock edge after the edge that accepts `start_i`.
- R9: While `done_o` is high and `ack_i` is low, `done_o` stays high and `result_o` stays stable. The edge that samples `ack_i` high returns the unit to idle, so `busy_o` reads low after it.
- R10: During and directly after reset, `busy_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request pulse, taken only when idle |
| op_i | input | 2 | Operation: 00 signed quotient, 01 unsigned quotient, 10 signed remainder, 11 unsigned remainder |
| dividend_i | input | DATA_W | Dividend, sampled with start |
| divisor_i | input | DATA_W | Divisor, sampled with start |
| ack_i | input | 1 | Consumer has taken the result |
| busy_o | output | 1 | Unit is computing or holding a result |
| done_o | output | 1 | `result_o` is valid |
| result_o | output | DATA_W | Selected quotient or remainder |

## Verification
The bench builds the unit with its default `DATA_W` of 32. At that width the full-range operands become reachable, so the test covers the most negative value, all-ones divisors, and dividends whose top bit is set for the unsigned forms. A 32-bit width also makes the 32-step latency and the overflow pair directly observable. A vector table exercises every sign combination against each of the four operations. Directed sequences follow it: start pulses during computation and during the hold, a long unacknowledged hold, and the reset state.

// File: rtl/int_div_pkg.sv
package int_div_pkg;

   typedef enum logic [1:0] {
      OP_SQUOT = 2'b00,
      OP_UQUOT = 2'b01,
      OP_SREM  = 2'b10,
      OP_UREM  = 2'b11
   } div_op_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_CALC = 2'd1,
      ST_DONE = 2'd2
   } div_state_e;

   function automatic logic op_signed(div_op_e op);
      return ~op[0];
   endfunction

   function automatic logic op_wants_rem(div_op_e op);
      return op[1];
   endfunction

endpackage

// File: rtl/div_operand_prep.sv
module div_operand_prep #(
   parameter int DATA_W = 32
) (
   input  logic              is_signed_i,
   input  logic [DATA_W-1:0] dividend_i,
   input  logic [DATA_W-1:0] divisor_i,
   output logic [DATA_W-1:0] a_mag_o,
   output logic [DATA_W-1:0] b_mag_o,
   output logic              a_neg_o,
   output logic              b_neg_o,
   output logic              b_zero_o
);
   localparam int MSB = DATA_W - 1;

   always_comb begin
      a_neg_o  = is_signed_i & dividend_i[MSB];
      b_neg_o  = is_signed_i & divisor_i[MSB];
      b_zero_o = (divisor_i == '0);
      a_mag_o  = a_neg_o ? (~dividend_i + 1'b1) : dividend_i;
      b_mag_o  = b_neg_o ? (~divisor_i + 1'b1) : divisor_i;
   end
endmodule

// File: rtl/div_iter_core.sv
module div_iter_core #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              step_i,
   input  logic [DATA_W-1:0] a_mag_i,
   input  logic [DATA_W-1:0] b_mag_i,
   output logic [DATA_W-1:0] quot_o,
   output logic [DATA_W-1:0] rem_o
);
   localparam int EXT_W = DATA_W + 1;

   logic [DATA_W-1:0] quot_q, rem_q, div_q;
   logic [EXT_W-1:0]  shifted, trial;
   logic              fits;

   always_comb begin
      shifted = {rem_q, quot_q[DATA_W-1]};
      trial   = shifted - {1'b0, div_q};
      fits    = ~trial[DATA_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         quot_q <= '0;
         rem_q  <= '0;
         div_q  <= '0;
      end else if (load_i) begin
         quot_q <= a_mag_i;
         rem_q  <= '0;
         div_q  <= b_mag_i;
      end else if (step_i) begin
         quot_q <= {quot_q[DATA_W-2:0], fits};
         rem_q  <= fits ? trial[DATA_W-1:0] : shifted[DATA_W-1:0];
      end
   end

   assign quot_o = quot_q;
   assign rem_o  = rem_q;
endmodule

// File: rtl/div_result_fix.sv
module div_result_fix
   import int_div_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  div_op_e           op_i,
   input  logic              a_neg_i,
   input  logic              b_neg_i,
   input  logic              b_zero_i,
   input  logic [DATA_W-1:0] quot_mag_i,
   input  logic [DATA_W-1:0] rem_mag_i,
   output logic [DATA_W-1:0] result_o
);
   logic              q_flip;
   logic [DATA_W-1:0] quot_fixed, rem_fixed;

   always_comb begin
      q_flip     = (a_neg_i ^ b_neg_i) & ~b_zero_i;
      quot_fixed = b_zero_i ? '1
                 : (q_flip ? (~quot_mag_i + 1'b1) : quot_mag_i);
      rem_fixed  = a_neg_i ? (~rem_mag_i + 1'b1) : rem_mag_i;
      result_o   = op_wants_rem(op_i) ? rem_fixed : quot_fixed;
   end
endmodule

// File: rtl/int_div_unit.sv
module int_div_unit
   import int_div_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [1:0]        op_i,
   input  logic [DATA_W-1:0] dividend_i,
   input  logic [DATA_W-1:0] divisor_i,
   input  logic              ack_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [DATA_W-1:0] result_o
);
   localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
   localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(DATA_W - 1);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("int_div_unit: DATA_W must be at least 2");
      end
   endgenerate

   div_state_e        state_q;
   logic [CNT_W-1:0]  step_q;
   div_op_e           op_q;
   logic              a_neg_q, b_neg_q, b_zero_q;

   logic              load, step;
   logic [DATA_W-1:0] a_mag, b_mag, quot_mag, rem_mag;
   logic              a_neg, b_neg, b_zero;

   assign load = (state_q == ST_IDLE) & start_i;
   assign step = (state_q == ST_CALC);

   div_operand_prep #(.DATA_W(DATA_W)) u_prep (
      .is_signed_i (op_signed(div_op_e'(op_i))),
      .dividend_i  (dividend_i),
      .divisor_i   (divisor_i),
      .a_mag_o     (a_mag),
      .b_mag_o     (b_mag),
      .a_neg_o     (a_neg),
      .b_neg_o     (b_neg),
      .b_zero_o    (b_zero)
   );

   div_iter_core #(.DATA_W(DATA_W)) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (load),
      .step_i  (step),
      .a_mag_i (a_mag),
      .b_mag_i (b_mag),
      .quot_o  (quot_mag),
      .rem_o   (rem_mag)
   );

   div_result_fix #(.DATA_W(DATA_W)) u_fix (
      .op_i       (op_q),
      .a_neg_i    (a_neg_q),
      .b_neg_i    (b_neg_q),
      .b_zero_i   (b_zero_q),
      .quot_mag_i (quot_mag),
      .rem_mag_i  (rem_mag),
      .result_o   (result_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         step_q   <= '0;
         op_q     <= OP_SQUOT;
         a_neg_q  <= 1'b0;
         b_neg_q  <= 1'b0;
         b_zero_q <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (start_i) begin
               state_q  <= ST_CALC;
               step_q   <= '0;
               op_q     <= div_op_e'(op_i);
               a_neg_q  <= a_neg;
               b_neg_q  <= b_neg;
               b_zero_q <= b_zero;
            end
            ST_CALC: begin
               step_q <= step_q + 1'b1;
               if (step_q == LAST_STEP) state_q <= ST_DONE;
            end
            ST_DONE: if (ack_i) state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o = (state_q != ST_IDLE);
   assign done_o = (state_q == ST_DONE);
endmodule

// File: rtl/div_unit_checker.sv
module div_unit_checker #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic [1:0]        op_i,
   input logic [DATA_W-1:0] dividend_i,
   input logic [DATA_W-1:0] divisor_i,
   input logic              ack_i,
   input logic              busy_o,
   input logic              done_o,
   input logic [DATA_W-1:0] result_o
);
   localparam int LAT_W = $clog2(DATA_W + 1) + 1;
   localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};

   logic [LAT_W-1:0]  lat_cnt;
   logic [DATA_W-1:0] cap_a, cap_b;
   logic [1:0]        cap_op;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_cnt <= '0;
         cap_a   <= '0;
         cap_b   <= '1;
         cap_op  <= 2'b01;
      end else if (!busy_o && start_i) begin
         lat_cnt <= '0;
         cap_a   <= dividend_i;
         cap_b   <= divisor_i;
         cap_op  <= op_i;
      end else if (busy_o && !done_o) begin
         lat_cnt <= lat_cnt + 1'b1;
      end
   end

   assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> (lat_cnt == LAT_W'(DATA_W)));

   assert_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && start_i) |=> (busy_o && !done_o));

   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !ack_i) |=> (done_o && $stable(result_o)));

   assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && ack_i) |=> !busy_o);

   assert_zero_quot_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && cap_b == '0 && !cap_op[1]) |-> (result_o == '1));

   assert_zero_rem_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && cap_b == '0 && cap_op[1]) |-> (result_o == cap_a));

   assert_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && cap_op == 2'b00 && cap_a == MOST_NEG && cap_b == '1)
      |-> (result_o == MOST_NEG));

   always_comb begin
      if (!rst_n) assert_reset_R10: assert (!busy_o && !done_o);
   end
endmodule

bind int_div_unit div_unit_checker #(.DATA_W(DATA_W)) u_div_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .op_i       (op_i),
   .dividend_i (dividend_i),
   .divisor_i  (divisor_i),
   .ack_i      (ack_i),
   .busy_o     (busy_o),
   .done_o     (done_o),
   .result_o   (result_o)
);

// File: tb/tb_int_div_unit.sv
module tb_int_div_unit;
   localparam int W = 32;
   localparam time CLK_PERIOD = 10ns;
   localparam int N_VEC = 22;

   // {req[3:0], op[1:0], dividend, divisor, expected}
   localparam logic [101:0] VEC [N_VEC] = '{
      {4'd1, 2'b01, 32'd100,        32'd7,          32'd14},         // R1
      {4'd4, 2'b11, 32'd100,        32'd7,          32'd2},          // R4
      {4'd2, 2'b00, 32'hFFFF_FFF9,  32'd2,          32'hFFFF_FFFD},  // R2 -7/2
      {4'd3, 2'b10, 32'hFFFF_FFF9,  32'd2,          32'hFFFF_FFFF},  // R3 -7%2
      {4'd2, 2'b00, 32'd7,          32'hFFFF_FFFE,  32'hFFFF_FFFD},  // R2 7/-2
      {4'd3, 2'b10, 32'd7,          32'hFFFF_FFFE,  32'd1},          // R3 7%-2
      {4'd2, 2'b00, 32'hFFFF_FFF9,  32'hFFFF_FFFE,  32'd3},          // R2 -7/-2
      {4'd3, 2'b10, 32'hFFFF_FFF9,  32'hFFFF_FFFE,  32'hFFFF_FFFF},  // R3 -7%-2
      {4'd1, 2'b01, 32'hFFFF_FFFF,  32'd1,          32'hFFFF_FFFF},  // R1
      {4'd1, 2'b01, 32'hFFFF_FFF9,  32'd2,          32'h7FFF_FFFC},  // R1
      {4'd4, 2'b11, 32'hFFFF_FFF9,  32'd2,          32'd1},          // R4
      {4'd2, 2'b00, 32'h8000_0000,  32'd2,          32'hC000_0000},  // R2
      {4'd1, 2'b01, 32'd5,          32'd9,          32'd0},          // R1
      {4'd4, 2'b11, 32'd5,          32'd9,          32'd5},          // R4
      {4'd1, 2'b01, 32'h1234_5678,  32'h100,        32'h0012_3456},  // R1
      {4'd4, 2'b11, 32'h1234_5678,  32'h100,        32'h78},         // R4
      {4'd5, 2'b01, 32'd1234,       32'd0,          32'hFFFF_FFFF},  // R5
      {4'd5, 2'b00, 32'hFFFF_FFF9,  32'd0,          32'hFFFF_FFFF},  // R5
      {4'd5, 2'b10, 32'hFFFF_FFF9,  32'd0,          32'hFFFF_FFF9},  // R5
      {4'd5, 2'b11, 32'd1234,       32'd0,          32'd1234},       // R5
      {4'd6, 2'b00, 32'h8000_0000,  32'hFFFF_FFFF,  32'h8000_0000},  // R6
      {4'd6, 2'b10, 32'h8000_0000,  32'hFFFF_FFFF,  32'd0}           // R6
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start_i = 1'b0;
   logic [1:0]   op_i = 2'b00;
   logic [W-1:0] dividend_i = '0;
   logic [W-1:0] divisor_i = '0;
   logic         ack_i = 1'b0;
   logic         busy_o, done_o;
   logic [W-1:0] result_o;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   int_div_unit #(.DATA_W(W)) dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .op_i       (op_i),
      .dividend_i (dividend_i),
      .divisor_i  (divisor_i),
      .ack_i      (ack_i),
      .busy_o     (busy_o),
      .done_o     (done_o),
      .result_o   (result_o)
   );

   task automatic check(input logic ok, input string req,
                        input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic run_op(input logic [1:0] op, input logic [W-1:0] a,
                         input logic [W-1:0] b, output logic [W-1:0] res,
                         output int lat);
      @(negedge clk);
      op_i = op; dividend_i = a; divisor_i = b; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      lat = 0;
      while (!done_o && lat < 200) begin
         @(negedge clk);
         lat++;
      end
      res = result_o;
   endtask

   task automatic acknowledge();
      ack_i = 1'b1;
      @(negedge clk);
      ack_i = 1'b0;
      check(!busy_o && !done_o, "R9 idle after ack", {31'd0, busy_o}, '0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL R8 watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [W-1:0] res;
      int lat;

      // R10: reset state
      repeat (3) @(negedge clk);
      check(!busy_o && !done_o, "R10 reset", {30'd0, busy_o, done_o}, '0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy_o && !done_o, "R10 after reset", {30'd0, busy_o, done_o}, '0);

      // table walk: R1..R6, latency R8
      for (int i = 0; i < N_VEC; i++) begin
         run_op(VEC[i][97:96], VEC[i][95:64], VEC[i][63:32], res, lat);
         checks++;
         if (res !== VEC[i][31:0]) begin
            errors++;
            $display("FAIL R%0d vector %0d actual=%h expected=%h",
                     VEC[i][101:98], i, res, VEC[i][31:0]);
         end
         check(lat == W, "R8 latency", W'(lat), W'(W));
         acknowledge();
      end

      // R9: long hold without ack; R7: start during hold ignored
      run_op(2'b01, 32'd1000, 32'd3, res, lat);
      check(res == 32'd333, "R1 hold setup", res, 32'd333);
      repeat (5) @(negedge clk);
      check(done_o && result_o == 32'd333, "R9 hold", result_o, 32'd333);
      op_i = 2'b11; dividend_i = 32'd10; divisor_i = 32'd4; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      @(negedge clk);
      check(done_o && result_o == 32'd333, "R7 start in hold", result_o, 32'd333);
      acknowledge();

      // R7: start pulse during computation ignored
      @(negedge clk);
      op_i = 2'b00; dividend_i = 32'hFFFF_FF9C; divisor_i = 32'd7; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      repeat (5) @(negedge clk);
      op_i = 2'b01; dividend_i = 32'd50; divisor_i = 32'd5; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      lat = 0;
      while (!done_o && lat < 200) begin
         @(negedge clk);
         lat++;
      end
      check(result_o == 32'hFFFF_FFF2, "R7 start in calc", result_o, 32'hFFFF_FFF2);
      check(lat == W - 6, "R7 R8 timing kept", W'(lat), W'(W - 6));
      acknowledge();

      // R9: stays idle without start
      repeat (3) @(negedge clk);
      check(!busy_o, "R9 stays idle", {31'd0, busy_o}, '0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule